// File: doc/BRIEF.md
# Character Bank Switching Cartridge Mapper

This block sits between an 8-bit console's CPU and picture-processor buses and the cartridge memories. A CPU write that lands anywhere in the low cartridge window $6000–$7FFF loads a two-bit bank number into a latch. The two low data bits swap places on the way in. The latched number, wrapped to the count of banks actually fitted, selects which 8 KiB slice of character memory the picture processor sees across its whole pattern range $0000–$1FFF.

Program memory is one fixed 32 KiB region, so its address passes straight through from the CPU. The nametable mirroring output follows a static configuration input, and the interrupt output never asserts. When a board has no character ROM, the 8 KiB character space acts as RAM, and the block produces the write enable for it. The memory arrays themselves are outside the block.

Top module: `chr_bank_mapper`

## Requirements
- R1: On a rising clock edge with `cpu_wr`, `cpu_en` high and `cpu_addr` in $6000–$7FFF, the bank latch loads {cpu_data[0], cpu_data[1]}. Data bit 0 becomes bank bit 1 and data bit 1 becomes bank bit 0, so 0x01 selects bank 2 and 0x02 selects bank 1. The new bank shows on `chr_addr` in the cycle after that edge.
- R2: A write at an address of $8000 or above or below $6000, or with `cpu_en` low, leaves the bank unchanged.
- R3: Data bits 7:2 have no effect on the bank, so a write of 0xFC selects bank 0.
- R4: Reset is synchronous and active-high. The bank is 0 after any clock edge with `rst` high.
- R5: `chr_addr` equals {effective bank, ppu_addr[12:0]}, which is bits 14:13 for the bank and 12:0 for the offset. `chr_sel` is high exactly when ppu_addr[13] is 0.
- R6: The effective bank is the latched bank modulo `bank_count` when `bank_count` is 1 to 4. A value of 0 uses the latched bank unchanged.
- R7: `prg_addr` equals cpu_addr[14:0] and `prg_sel` equals cpu_addr[15], regardless of any register write.
- R8: `irq` is 0 at all times.
- R9: `mirror_out` always equals `mirror_cfg`, and register writes do not change it.
- R10: `chr_ram_we` is high exactly when `ppu_wr` is high, ppu_addr[13] is 0 and `chr_rom_present` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_en | input | 1 | Write enable qualifier for the bank register |
| ppu_addr | input | 14 | Picture-processor address |
| ppu_wr | input | 1 | Picture-processor write strobe |
| chr_rom_present | input | 1 | High when character ROM is fitted |
| mirror_cfg | input | 1 | Static nametable mirroring setting |
| bank_count | input | 3 | Number of fitted character banks (0 means no wrap) |
| prg_addr | output | 15 | Program ROM address |
| prg_sel | output | 1 | Program ROM region select |
| chr_addr | output | 15 | Character memory address |
| chr_sel | output | 1 | Character memory region select |
| chr_ram_we | output | 1 | Character RAM write enable |
| mirror_out | output | 1 | Nametable mirroring output |
| irq | output | 1 | Interrupt request, never asserted |

## Verification
The assertions assume `bank_count` and `mirror_cfg` are static between checks. They also assume the CPU strobe and data are stable around each rising edge, so the sampled write is the one that was intended. The stimulus changes every input only on the falling edge. It sets `bank_count` to 4 during the bit-swap and decode tests and changes it only for the wrap tests. It drives each write for exactly one cycle.

// File: rtl/chrmap_pkg.sv
package chrmap_pkg;
  localparam int CPU_AW  = 16;
  localparam int DATA_W  = 8;
  localparam int PPU_AW  = 14;
  localparam int BANK_W  = 2;
  localparam int CNT_W   = BANK_W + 1;
  localparam int OFS_W   = PPU_AW - 1;
  localparam int CHR_AW  = BANK_W + OFS_W;
  localparam int PRG_AW  = CPU_AW - 1;

  // Reverse the low BANK_W data bits to form the bank number.
  function automatic logic [BANK_W-1:0] swap_bits(input logic [DATA_W-1:0] d);
    logic [BANK_W-1:0] b;
    for (int i = 0; i < BANK_W; i++) b[i] = d[BANK_W-1-i];
    return b;
  endfunction

  // Reduce the bank modulo the fitted count; 0 or oversize count leaves it as is.
  function automatic logic [BANK_W-1:0] wrap_bank(input logic [BANK_W-1:0] raw,
                                                  input logic [CNT_W-1:0] cnt);
    logic [CNT_W-1:0] wide;
    logic [CNT_W-1:0] res;
    wide = {1'b0, raw};
    if (cnt == '0 || cnt > CNT_W'(1 << BANK_W)) res = wide;
    else res = wide % cnt;
    return res[BANK_W-1:0];
  endfunction
endpackage

// File: rtl/chrmap_decode.sv
module chrmap_decode #(
  parameter int CPU_AW = chrmap_pkg::CPU_AW,
  parameter logic [CPU_AW-1:0] WIN_LO = 16'h6000,
  parameter logic [CPU_AW-1:0] WIN_HI = 16'h7FFF
) (
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_en,
  output logic              wr_hit
);
  logic in_window;
  always_comb begin
    in_window = (cpu_addr >= WIN_LO) && (cpu_addr <= WIN_HI);
    wr_hit    = cpu_wr && cpu_en && in_window;
  end
endmodule

// File: rtl/chrmap_bank_latch.sv
module chrmap_bank_latch
  import chrmap_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int BW = BANK_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_hit,
  input  logic [DW-1:0] cpu_data,
  output logic [BW-1:0] bank_q
);
  always_ff @(posedge clk) begin
    if (rst)         bank_q <= '0;
    else if (wr_hit) bank_q <= swap_bits(cpu_data);
  end
endmodule

// File: rtl/chrmap_addr_gen.sv
module chrmap_addr_gen
  import chrmap_pkg::*;
#(
  parameter int BW  = BANK_W,
  parameter int CW  = CNT_W,
  parameter int PAW = PPU_AW,
  localparam int OW = PAW - 1,
  localparam int AW = BW + OW
) (
  input  logic [BW-1:0]  bank_q,
  input  logic [CW-1:0]  bank_count,
  input  logic [PAW-1:0] ppu_addr,
  input  logic           ppu_wr,
  input  logic           chr_rom_present,
  output logic [AW-1:0]  chr_addr,
  output logic           chr_sel,
  output logic           chr_ram_we
);
  logic [BW-1:0] eff_bank;
  always_comb begin
    eff_bank   = wrap_bank(bank_q, bank_count);
    chr_addr   = {eff_bank, ppu_addr[OW-1:0]};
    chr_sel    = ~ppu_addr[PAW-1];
    chr_ram_we = ppu_wr && chr_sel && !chr_rom_present;
  end
endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper
  import chrmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_wr,
  input  logic              cpu_en,
  input  logic [PPU_AW-1:0] ppu_addr,
  input  logic              ppu_wr,
  input  logic              chr_rom_present,
  input  logic              mirror_cfg,
  input  logic [CNT_W-1:0]  bank_count,
  output logic [PRG_AW-1:0] prg_addr,
  output logic              prg_sel,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              chr_sel,
  output logic              chr_ram_we,
  output logic              mirror_out,
  output logic              irq
);
  // Internal events brought out as named wires for the checker.
  logic              wr_hit;
  logic [BANK_W-1:0] bank_q;

  chrmap_decode u_decode (
    .cpu_addr (cpu_addr),
    .cpu_wr   (cpu_wr),
    .cpu_en   (cpu_en),
    .wr_hit   (wr_hit)
  );

  chrmap_bank_latch u_latch (
    .clk      (clk),
    .rst      (rst),
    .wr_hit   (wr_hit),
    .cpu_data (cpu_data),
    .bank_q   (bank_q)
  );

  chrmap_addr_gen u_addr (
    .bank_q          (bank_q),
    .bank_count      (bank_count),
    .ppu_addr        (ppu_addr),
    .ppu_wr          (ppu_wr),
    .chr_rom_present (chr_rom_present),
    .chr_addr        (chr_addr),
    .chr_sel         (chr_sel),
    .chr_ram_we      (chr_ram_we)
  );

  always_comb begin
    prg_addr   = cpu_addr[PRG_AW-1:0];
    prg_sel    = cpu_addr[CPU_AW-1];
    mirror_out = mirror_cfg;
    irq        = 1'b0;
  end
endmodule

// File: rtl/chrmap_checker.sv
module chrmap_checker
  import chrmap_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_data,
  input logic              cpu_wr,
  input logic [PPU_AW-1:0] ppu_addr,
  input logic              ppu_wr,
  input logic              chr_rom_present,
  input logic              mirror_cfg,
  input logic [CNT_W-1:0]  bank_count,
  input logic [CHR_AW-1:0] chr_addr,
  input logic              chr_ram_we,
  input logic              mirror_out,
  input logic              irq,
  input logic              wr_hit,
  input logic [BANK_W-1:0] bank_q
);
  assert_latch_swap_R1: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (bank_q == {$past(cpu_data[0]), $past(cpu_data[1])}));

  assert_hold_no_hit_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(bank_q));

  assert_rom_write_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr[CPU_AW-1]) |=> $stable(bank_q));

  assert_reset_zero_R4: assert property (@(posedge clk)
    rst |=> (bank_q == '0));

  assert_offset_pass_R5: assert property (@(posedge clk) disable iff (rst)
    chr_addr[CHR_AW-BANK_W-1:0] == ppu_addr[PPU_AW-2:0]);

  assert_wrap_range_R6: assert property (@(posedge clk) disable iff (rst)
    (bank_count != '0 && bank_count <= CNT_W'(1 << BANK_W))
      |-> ({1'b0, chr_addr[CHR_AW-1:CHR_AW-BANK_W]} < bank_count));

  assert_irq_idle_R8: assert property (@(posedge clk) disable iff (rst)
    irq == 1'b0);

  assert_mirror_follow_R9: assert property (@(posedge clk) disable iff (rst)
    mirror_out == mirror_cfg);

  assert_ram_we_gate_R10: assert property (@(posedge clk) disable iff (rst)
    chr_ram_we |-> (ppu_wr && !chr_rom_present && !ppu_addr[PPU_AW-1]));
endmodule

bind chr_bank_mapper chrmap_checker u_chk (
  .clk             (clk),
  .rst             (rst),
  .cpu_addr        (cpu_addr),
  .cpu_data        (cpu_data),
  .cpu_wr          (cpu_wr),
  .ppu_addr        (ppu_addr),
  .ppu_wr          (ppu_wr),
  .chr_rom_present (chr_rom_present),
  .mirror_cfg      (mirror_cfg),
  .bank_count      (bank_count),
  .chr_addr        (chr_addr),
  .chr_ram_we      (chr_ram_we),
  .mirror_out      (mirror_out),
  .irq             (irq),
  .wr_hit          (wr_hit),
  .bank_q          (bank_q)
);

// File: tb/chr_bank_mapper_tb_top.sv
`timescale 1ns/100ps
module chr_bank_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_en = 1'b1;
  logic [13:0] ppu_addr = '0;
  logic        ppu_wr = 1'b0;
  logic        chr_rom_present = 1'b1;
  logic        mirror_cfg = 1'b1;
  logic [2:0]  bank_count = 3'd4;
  logic [14:0] prg_addr;
  logic        prg_sel;
  logic [14:0] chr_addr;
  logic        chr_sel;
  logic        chr_ram_we;
  logic        mirror_out;
  logic        irq;

  always #2.5 clk = ~clk;

  chr_bank_mapper dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .cpu_en(cpu_en), .ppu_addr(ppu_addr), .ppu_wr(ppu_wr),
    .chr_rom_present(chr_rom_present), .mirror_cfg(mirror_cfg),
    .bank_count(bank_count), .prg_addr(prg_addr), .prg_sel(prg_sel),
    .chr_addr(chr_addr), .chr_sel(chr_sel), .chr_ram_we(chr_ram_we),
    .mirror_out(mirror_out), .irq(irq)
  );

  typedef enum int {K_CHR, K_CSEL, K_PRG, K_PSEL, K_IRQ, K_MIR, K_WE} kind_t;
  typedef struct {
    kind_t       kind;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [15:0] observe(kind_t k);
    case (k)
      K_CHR:  return {1'b0, chr_addr};
      K_CSEL: return {15'd0, chr_sel};
      K_PRG:  return {1'b0, prg_addr};
      K_PSEL: return {15'd0, prg_sel};
      K_IRQ:  return {15'd0, irq};
      K_MIR:  return {15'd0, mirror_out};
      default: return {15'd0, chr_ram_we};
    endcase
  endfunction

  // Monitor: pops expectations pushed just after an edge and compares.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = q.pop_front();
        act = observe(it.kind);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, input logic en);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_en = en; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_en = 1'b1;
  endtask

  task automatic expect_out(input kind_t k, input logic [15:0] e, input string req);
    @(posedge clk);
    #1;
    q.push_back('{kind: k, exp: e, req: req});
  endtask

  // Expected character address from the requirements: bank in 14:13, offset 12:0.
  task automatic expect_chr(input logic [13:0] pa, input logic [1:0] bank, input string req);
    @(negedge clk);
    ppu_addr = pa;
    expect_out(K_CHR, {1'b0, bank, pa[12:0]}, req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_chr(14'h0000, 2'd0, "R4");
    expect_out(K_IRQ, 16'd0, "R8");

    cpu_write(16'h6000, 8'h01, 1'b1);
    expect_chr(14'h0123, 2'd2, "R1");
    cpu_write(16'h6000, 8'h02, 1'b1);
    expect_chr(14'h0000, 2'd1, "R1");
    cpu_write(16'h7FFF, 8'h03, 1'b1);
    expect_chr(14'h1FFF, 2'd3, "R5");
    @(negedge clk); ppu_addr = 14'h2000;
    expect_out(K_CSEL, 16'd0, "R5");
    @(negedge clk); ppu_addr = 14'h1FFF;
    expect_out(K_CSEL, 16'd1, "R5");

    cpu_write(16'h8000, 8'h01, 1'b1);
    expect_chr(14'h0000, 2'd3, "R2");
    cpu_write(16'hFFFF, 8'h00, 1'b1);
    expect_chr(14'h0000, 2'd3, "R2");
    cpu_write(16'h5FFF, 8'h00, 1'b1);
    expect_chr(14'h0000, 2'd3, "R2");
    cpu_write(16'h6800, 8'h00, 1'b0);
    expect_chr(14'h0000, 2'd3, "R2");

    cpu_write(16'h6000, 8'hFC, 1'b1);
    expect_chr(14'h0040, 2'd0, "R3");
    cpu_write(16'h7000, 8'hFE, 1'b1);
    expect_chr(14'h0040, 2'd1, "R3");

    cpu_write(16'h6000, 8'h03, 1'b1);
    @(negedge clk); bank_count = 3'd3;
    expect_chr(14'h0000, 2'd0, "R6");
    @(negedge clk); bank_count = 3'd1;
    expect_chr(14'h0000, 2'd0, "R6");
    cpu_write(16'h6000, 8'h01, 1'b1);
    @(negedge clk); bank_count = 3'd3;
    expect_chr(14'h0000, 2'd2, "R6");
    @(negedge clk); bank_count = 3'd0;
    cpu_write(16'h6000, 8'h03, 1'b1);
    expect_chr(14'h0000, 2'd3, "R6");
    @(negedge clk); bank_count = 3'd4;

    @(negedge clk); cpu_addr = 16'hC123;
    expect_out(K_PRG, 16'h4123, "R7");
    expect_out(K_PSEL, 16'd1, "R7");
    cpu_write(16'h6000, 8'hFF, 1'b1);
    @(negedge clk); cpu_addr = 16'h8ABC;
    expect_out(K_PRG, 16'h0ABC, "R7");
    expect_out(K_IRQ, 16'd0, "R8");
    expect_out(K_MIR, 16'd1, "R9");
    @(negedge clk); mirror_cfg = 1'b0;
    expect_out(K_MIR, 16'd0, "R9");

    @(negedge clk); chr_rom_present = 1'b0; ppu_wr = 1'b1; ppu_addr = 14'h0100;
    expect_out(K_WE, 16'd1, "R10");
    @(negedge clk); ppu_addr = 14'h2100;
    expect_out(K_WE, 16'd0, "R10");
    @(negedge clk); chr_rom_present = 1'b1; ppu_addr = 14'h0100;
    expect_out(K_WE, 16'd0, "R10");
    @(negedge clk); chr_rom_present = 1'b0; ppu_wr = 1'b0;
    expect_out(K_WE, 16'd0, "R10");

    cpu_write(16'h6000, 8'h03, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    expect_chr(14'h0000, 2'd0, "R4");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule